// File: doc/BRIEF.md
# Flash Read Prefetch Accelerator

This block sits between a 32-bit instruction-fetch port and a wide, slow on-chip flash array. Each array access returns one whole line (128 bits by default, or 64 bits when a mode input selects the narrow width). A wait-state input adds extra cycles to every array access, and a value of zero gives single-cycle access. The CPU side can issue byte, halfword and word reads. The block serves each read from whichever line holds the addressed bytes.

Two line buffers hold recently fetched lines. After a demanded line arrives, the block fetches the following sequential line into the other buffer while the CPU consumes the current one. The two buffers swap roles as execution moves forward, so in-order code runs without stalls even at zero wait states. A disable input bypasses the buffers so that every read goes to the array. The array occupies less space than its address window, so its contents repeat across that window. The array itself is modelled inside the block as a synchronous read-only memory with a computed content.

Top module: `flash_prefetch_accel`

## Requirements
- R1: `rd_data` is valid only while `rd_ready` is high. `rd_size` 0 gives a byte: `rd_data[7:0]` holds the byte at `rd_addr[1:0]` and the upper bits are zero. `rd_size` 1 gives a halfword: `rd_data[15:0]` holds the halfword selected by `rd_addr[1]`, `rd_addr[0]` is ignored and the upper bits are zero. `rd_size` 2 or 3 gives the word at `rd_addr` with `rd_addr[1:0]` ignored. Lane order is little-endian.
- R2: A read whose line is held in a valid buffer raises `rd_ready` in the same cycle the request is presented. `rd_ready` is never high without `rd_req`.
- R3: A read that misses while the array is idle keeps `rd_ready` low for `cfg_wait`+1 cycles. It then returns the data with `rd_ready` high.
- R4: Once a demanded line has arrived, the next sequential line is fetched into the other buffer. At `cfg_wait` 0, in-order reads of every word or sub-word after the first miss complete without a stall.
- R5: Buffered lines stay usable across idle gaps and when the CPU moves back to the line in the other buffer.
- R6: A miss invalidates both buffers and fetches the demanded line first. If a prefetch is in flight, the miss waits for that prefetch to end and then re-checks the buffers. The two valid buffers never hold the same line.
- R7: Address bits at and above FLASH_AW are ignored, so the array contents repeat across the window.
- R8: The line after the last line of the array is line 0, and the prefetch wraps to it.
- R9: `cfg_narrow` 1 selects 8-byte lines and 0 selects 16-byte lines. This decides which addresses share a buffer.
- R10: With `cfg_seq_off` 1, no read is served from a buffer, and every read stalls for `cfg_wait`+1 cycles.
- R11: Any change of `cfg_wait`, `cfg_narrow` or `cfg_seq_off` invalidates both buffers and cancels an array access in flight. No read completes in that cycle.
- R12: After reset both buffers are empty, no array access is pending and `rd_ready` is low.
- R13: The array byte at flash offset a holds ((a mod 256) XOR 0x5C) + 37*(a div 256), taken modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wait | input | WS_W | Extra cycles per array access |
| cfg_narrow | input | 1 | 1 selects 64-bit lines, 0 selects 128-bit lines |
| cfg_seq_off | input | 1 | 1 bypasses the line buffers and stops the prefetch |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| rd_ready | output | 1 | Read completes this cycle |
| rd_data | output | 32 | Read data, lanes as in R1 |

## Verification
The bench builds the block with ADDR_W 20, FLASH_AW 10, LINE_BITS 128 and WS_W 4. With a 1 KiB array, aliasing needs only one address with high bits set, and the wrap from the last line to line 0 takes a single read. A 128-bit line width lets one build switch between both line widths at run time. A 4-bit wait field allows the three-wait-state case, where a sequential read catches up with a prefetch still in flight.

// File: rtl/flash_pf_pkg.sv
package flash_pf_pkg;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_WORD = 2'd2,
      XS_WRD2 = 2'd3
   } xfer_size_e;

   // Computed array content: byte at flash offset a
   function automatic logic [7:0] array_byte(input logic [31:0] a);
      logic [7:0] lo;
      logic [7:0] hi;
      lo = a[7:0] ^ 8'h5C;
      hi = a[15:8] * 8'd37;
      return lo + hi;
   endfunction

endpackage

// File: rtl/flash_line_array.sv
module flash_line_array #(
   parameter int unsigned FLASH_AW  = 10,
   parameter int unsigned WS_W      = 4,
   parameter int unsigned LINE_BITS = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [FLASH_AW-1:0]  start_base_i,
   input  logic [WS_W-1:0]      start_ws_i,
   input  logic                 cancel_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [FLASH_AW-1:0]  base_o,
   output logic [LINE_BITS-1:0] line_o
);
   import flash_pf_pkg::*;

   localparam int unsigned LBYTES = LINE_BITS / 8;

   logic                busy_q;
   logic [WS_W-1:0]     cnt_q;
   logic [FLASH_AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
      end else if (cancel_i) begin
         busy_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= start_ws_i;
         base_q <= start_base_i;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);
   assign base_o = base_q;

   for (genvar i = 0; i < LBYTES; i++) begin : g_byte
      logic [FLASH_AW-1:0] ofs;
      assign ofs = base_q + FLASH_AW'(i);
      assign line_o[8*i +: 8] = array_byte(32'(ofs));
   end

endmodule

// File: rtl/line_buffer_pair.sv
module line_buffer_pair #(
   parameter int unsigned FLASH_AW  = 10,
   parameter int unsigned LINE_BITS = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush_i,
   input  logic                       wr_en_i,
   input  logic                       wr_sel_i,
   input  logic [FLASH_AW-1:0]        wr_tag_i,
   input  logic [LINE_BITS-1:0]       wr_line_i,
   input  logic [FLASH_AW-1:0]        look_tag_i,
   output logic                       hit_o,
   output logic                       hit_sel_o,
   output logic [LINE_BITS-1:0]       hit_line_o,
   output logic [1:0]                 valid_o,
   output logic [1:0][FLASH_AW-1:0]   tags_o
);

   logic [1:0]                 hit_vec;
   logic [1:0][LINE_BITS-1:0]  lines;

   for (genvar b = 0; b < 2; b++) begin : g_buf
      logic                 v_q;
      logic [FLASH_AW-1:0]  t_q;
      logic [LINE_BITS-1:0] d_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (flush_i) begin
            v_q <= 1'b0;
         end else if (wr_en_i && (wr_sel_i == b[0])) begin
            v_q <= 1'b1;
            t_q <= wr_tag_i;
            d_q <= wr_line_i;
         end
      end

      assign valid_o[b] = v_q;
      assign tags_o[b]  = t_q;
      assign lines[b]   = d_q;
      assign hit_vec[b] = v_q && (t_q == look_tag_i);
   end

   assign hit_o      = |hit_vec;
   assign hit_sel_o  = hit_vec[1];
   assign hit_line_o = hit_vec[1] ? lines[1] : lines[0];

endmodule

// File: rtl/lane_extract.sv
module lane_extract #(
   parameter int unsigned LINE_BITS = 128,
   parameter int unsigned WI_W      = 2
) (
   input  logic [LINE_BITS-1:0] line_i,
   input  logic [WI_W-1:0]      word_idx_i,
   input  logic [1:0]           off_i,
   input  logic [1:0]           size_i,
   output logic [31:0]          data_o
);
   import flash_pf_pkg::*;

   logic [31:0] word;
   logic [31:0] sh_b;
   logic [31:0] sh_h;

   assign word = line_i[32*word_idx_i +: 32];
   assign sh_b = word >> {off_i, 3'b000};
   assign sh_h = word >> {off_i[1], 4'b0000};

   always_comb begin
      case (xfer_size_e'(size_i))
         XS_BYTE: data_o = {24'd0, sh_b[7:0]};
         XS_HALF: data_o = {16'd0, sh_h[15:0]};
         default: data_o = word;
      endcase
   end

endmodule

// File: rtl/flash_prefetch_accel.sv
module flash_prefetch_accel #(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned FLASH_AW  = 10,
   parameter int unsigned LINE_BITS = 128,
   parameter int unsigned WS_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WS_W-1:0]   cfg_wait,
   input  logic              cfg_narrow,
   input  logic              cfg_seq_off,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_size,
   output logic              rd_ready,
   output logic [31:0]       rd_data
);

   localparam int unsigned WORDS = LINE_BITS / 32;
   localparam int unsigned WI_W  = $clog2(WORDS);
   localparam int unsigned CFG_W = WS_W + 2;

   if (!(LINE_BITS == 64 || LINE_BITS == 128)) begin : g_bad_line
      $error("LINE_BITS must be 64 or 128");
   end
   if (FLASH_AW < 5 || FLASH_AW > ADDR_W || ADDR_W > 32) begin : g_bad_addr
      $error("need 5 <= FLASH_AW <= ADDR_W <= 32");
   end

   logic            narrow_eff;
   logic [WI_W-1:0] word_idx;

   if (LINE_BITS == 128) begin : g_dual
      assign narrow_eff = cfg_narrow;
      assign word_idx   = cfg_narrow ? {1'b0, rd_addr[2]} : rd_addr[3:2];
   end else begin : g_narrow
      assign narrow_eff = 1'b1;
      assign word_idx   = rd_addr[2];
   end

   logic [FLASH_AW-1:0] flash_addr;
   logic [FLASH_AW-1:0] line_base;
   logic [FLASH_AW-1:0] line_step;
   assign flash_addr = rd_addr[FLASH_AW-1:0];
   assign line_base  = narrow_eff ? {flash_addr[FLASH_AW-1:3], 3'b000}
                                  : {flash_addr[FLASH_AW-1:4], 4'b0000};
   assign line_step  = narrow_eff ? FLASH_AW'(8) : FLASH_AW'(16);

   // configuration tracking
   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;
   logic             seq_on;
   assign cfg_now = {cfg_wait, narrow_eff, cfg_seq_off};
   assign cfg_chg = (cfg_now != cfg_q);
   assign seq_on  = !cfg_seq_off;

   // array and buffers
   logic                       fa_start;
   logic [FLASH_AW-1:0]        fa_start_base;
   logic                       fa_busy;
   logic                       fa_done;
   logic [FLASH_AW-1:0]        fa_base;
   logic [LINE_BITS-1:0]       fa_line;
   logic                       bh_hit;
   logic                       bh_sel;
   logic [LINE_BITS-1:0]       bh_line;
   logic [1:0]                 buf_valid;
   logic [1:0][FLASH_AW-1:0]   buf_tags;

   // control state
   logic                cur_v;
   logic                cur_buf;
   logic [FLASH_AW-1:0] cur_base;
   logic                fa_dem_q;
   logic                fa_buf_q;

   logic                hit;
   logic                dem_done;
   logic                miss_issue;
   logic                pf_issue;
   logic [FLASH_AW-1:0] pf_target;
   logic                other_has;
   logic                buf_wr;
   logic                buf_flush;

   assign pf_target  = cur_base + line_step;
   assign other_has  = buf_valid[!cur_buf] && (buf_tags[!cur_buf] == pf_target);
   assign hit        = bh_hit && seq_on && !cfg_chg;
   assign dem_done   = fa_done && fa_dem_q && !cfg_chg;
   assign miss_issue = rd_req && !hit && !fa_busy && !cfg_chg;
   assign pf_issue   = seq_on && cur_v && !other_has && !fa_busy
                       && !cfg_chg && !miss_issue;
   assign fa_start      = miss_issue || pf_issue;
   assign fa_start_base = miss_issue ? line_base : pf_target;
   assign buf_wr        = fa_done && seq_on && !cfg_chg;
   assign buf_flush     = cfg_chg || miss_issue;

   flash_line_array #(
      .FLASH_AW (FLASH_AW),
      .WS_W     (WS_W),
      .LINE_BITS(LINE_BITS)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (fa_start),
      .start_base_i(fa_start_base),
      .start_ws_i  (cfg_wait),
      .cancel_i    (cfg_chg),
      .busy_o      (fa_busy),
      .done_o      (fa_done),
      .base_o      (fa_base),
      .line_o      (fa_line)
   );

   line_buffer_pair #(
      .FLASH_AW (FLASH_AW),
      .LINE_BITS(LINE_BITS)
   ) u_bufs (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (buf_flush),
      .wr_en_i   (buf_wr),
      .wr_sel_i  (fa_buf_q),
      .wr_tag_i  (fa_base),
      .wr_line_i (fa_line),
      .look_tag_i(line_base),
      .hit_o     (bh_hit),
      .hit_sel_o (bh_sel),
      .hit_line_o(bh_line),
      .valid_o   (buf_valid),
      .tags_o    (buf_tags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         cur_v    <= 1'b0;
         cur_buf  <= 1'b0;
         cur_base <= '0;
         fa_dem_q <= 1'b0;
         fa_buf_q <= 1'b0;
      end else begin
         cfg_q <= cfg_now;
         if (fa_start) begin
            fa_dem_q <= miss_issue;
            fa_buf_q <= miss_issue ? 1'b0 : !cur_buf;
         end
         if (buf_flush) begin
            cur_v <= 1'b0;
         end else if (hit) begin
            cur_v    <= 1'b1;
            cur_buf  <= bh_sel;
            cur_base <= line_base;
         end else if (dem_done && seq_on) begin
            cur_v    <= 1'b1;
            cur_buf  <= fa_buf_q;
            cur_base <= fa_base;
         end
      end
   end

   assign rd_ready = rd_req && (hit || dem_done);

   lane_extract #(
      .LINE_BITS(LINE_BITS),
      .WI_W     (WI_W)
   ) u_lanes (
      .line_i    (hit ? bh_line : fa_line),
      .word_idx_i(word_idx),
      .off_i     (rd_addr[1:0]),
      .size_i    (rd_size),
      .data_o    (rd_data)
   );

endmodule

// File: rtl/flash_prefetch_chk.sv
module flash_prefetch_chk #(
   parameter int unsigned FLASH_AW = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_req,
   input logic                rd_ready,
   input logic                cfg_seq_off,
   input logic                cfg_chg,
   input logic                fa_busy,
   input logic                fa_done,
   input logic [1:0]          buf_valid,
   input logic [FLASH_AW-1:0] tag_a,
   input logic [FLASH_AW-1:0] tag_b
);

   // R2
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> rd_req);

   // R3
   miss_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready && !fa_busy && !cfg_chg) |=> fa_busy);

   // R10
   bypass_from_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_seq_off && rd_ready) |-> fa_done);

   // R11
   flush_on_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> (buf_valid == 2'b00));

   // R6
   distinct_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&buf_valid) |-> (tag_a != tag_b));

   // R12
   empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((buf_valid == 2'b00) && !fa_busy && !rd_ready));

endmodule

bind flash_prefetch_accel flash_prefetch_chk #(.FLASH_AW(FLASH_AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_req     (rd_req),
   .rd_ready   (rd_ready),
   .cfg_seq_off(cfg_seq_off),
   .cfg_chg    (cfg_chg),
   .fa_busy    (fa_busy),
   .fa_done    (fa_done),
   .buf_valid  (buf_valid),
   .tag_a      (buf_tags[0]),
   .tag_b      (buf_tags[1])
);

// File: tb/test_flash_prefetch_accel.sv
module test_flash_prefetch_accel;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 20;
   localparam int FLASH_AW   = 10;
   localparam int LINE_BITS  = 128;
   localparam int WS_W       = 4;

   typedef struct packed {
      logic [3:0]  idle;
      logic [3:0]  stalls;
      logic [1:0]  size;
      logic [19:0] addr;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 4'd1, 2'd2, 20'h00000},   // R3 first miss
      '{4'd0, 4'd0, 2'd2, 20'h00004},   // R2 hit
      '{4'd0, 4'd0, 2'd0, 20'h00009},   // R1 byte
      '{4'd0, 4'd0, 2'd1, 20'h0000E},   // R1 upper half
      '{4'd0, 4'd0, 2'd2, 20'h00010},   // R4 prefetched line
      '{4'd0, 4'd0, 2'd0, 20'h00015},
      '{4'd0, 4'd0, 2'd1, 20'h0001A},
      '{4'd0, 4'd0, 2'd2, 20'h0001C},
      '{4'd0, 4'd0, 2'd2, 20'h00020},   // R4 third line, no stall
      '{4'd0, 4'd0, 2'd1, 20'h00026},
      '{4'd0, 4'd2, 2'd2, 20'h00100},   // R6 jump waits on prefetch
      '{4'd0, 4'd0, 2'd2, 20'h00104},
      '{4'd0, 4'd0, 2'd0, 20'hFFD0B},   // R7 alias of 0x10B
      '{4'd0, 4'd1, 2'd2, 20'h003FC},   // R6 miss on last line
      '{4'd2, 4'd0, 2'd0, 20'h00003}    // R8 wrapped prefetch
   };
   localparam string VTAG [NV] = '{"R3", "R2", "R1", "R1", "R4", "R4", "R4",
      "R4", "R4", "R1", "R6", "R2", "R7", "R6", "R8"};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [WS_W-1:0]   cfg_wait = '0;
   logic              cfg_narrow = 1'b0;
   logic              cfg_seq_off = 1'b0;
   logic              rd_req = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [1:0]        rd_size = 2'd2;
   logic              rd_ready;
   logic [31:0]       rd_data;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD/2) clk = !clk;

   flash_prefetch_accel #(
      .ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .LINE_BITS(LINE_BITS), .WS_W(WS_W)
   ) i_flash_prefetch_accel (
      .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_narrow(cfg_narrow),
      .cfg_seq_off(cfg_seq_off), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_size(rd_size), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   // R13 content formula
   function automatic logic [7:0] mem_byte(input int a);
      int v;
      v = ((a % 256) ^ 'h5C) + 37 * (a / 256);
      return 8'(v % 256);
   endfunction

   function automatic logic [31:0] expect_data(input logic [19:0] addr, input logic [1:0] sz);
      int fa;
      int wb;
      fa = int'(addr) % (1 << FLASH_AW);
      wb = fa - (fa % 4);
      if (sz == 2'd0) return {24'd0, mem_byte(fa)};
      if (sz == 2'd1) return {16'd0, mem_byte(wb + 2*((fa/2)%2) + 1), mem_byte(wb + 2*((fa/2)%2))};
      return {mem_byte(wb+3), mem_byte(wb+2), mem_byte(wb+1), mem_byte(wb)};
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_req = 1'b0;
      end
   endtask

   task automatic read_chk(input logic [19:0] addr, input logic [1:0] sz,
                           input int exp_stalls, input string tag);
      int st;
      logic [31:0] exp;
      @(negedge clk);
      rd_req  = 1'b1;
      rd_addr = addr;
      rd_size = sz;
      st = 0;
      #1;
      while (!rd_ready && st < 40) begin
         @(negedge clk);
         #1;
         st++;
      end
      exp = expect_data(addr, sz);
      check(rd_data == exp, tag, "data", rd_data, exp);
      check(st == exp_stalls, tag, "stall cycles", 32'(st), 32'(exp_stalls));
   endtask

   task automatic set_cfg(input logic [WS_W-1:0] w, input logic nar, input logic off);
      @(negedge clk);
      rd_req      = 1'b0;
      cfg_wait    = w;
      cfg_narrow  = nar;
      cfg_seq_off = off;
      idle(2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R12 idle after reset
      check(rd_ready == 1'b0, "R12", "ready after reset", 32'(rd_ready), 32'd0);

      for (int k = 0; k < NV; k++) begin
         idle(int'(VECS[k].idle));
         read_chk(VECS[k].addr, VECS[k].size, int'(VECS[k].stalls), VTAG[k]);
      end

      // R3 three wait states, then R4 catch-up on an in-flight prefetch
      set_cfg(4'd3, 1'b0, 1'b0);
      read_chk(20'h00040, 2'd2, 4, "R3");
      read_chk(20'h00044, 2'd2, 0, "R2");
      read_chk(20'h00048, 2'd2, 0, "R2");
      read_chk(20'h0004C, 2'd2, 0, "R2");
      read_chk(20'h00050, 2'd2, 2, "R4");

      // R11 wait-state change drops the buffered line 0x050
      set_cfg(4'd0, 1'b0, 1'b0);
      read_chk(20'h00054, 2'd2, 1, "R11");

      // R9 narrow lines: 0x058 is a separate line
      set_cfg(4'd0, 1'b1, 1'b0);
      read_chk(20'h00050, 2'd2, 1, "R9");
      read_chk(20'h00054, 2'd2, 0, "R9");
      read_chk(20'h0005A, 2'd1, 1, "R9");
      read_chk(20'h0005C, 2'd2, 0, "R9");

      // R10 buffers bypassed
      set_cfg(4'd0, 1'b0, 1'b1);
      read_chk(20'h00080, 2'd2, 1, "R10");
      read_chk(20'h00084, 2'd2, 1, "R10");
      read_chk(20'h00080, 2'd0, 1, "R10");

      // R5 retention across a gap and a step back
      set_cfg(4'd0, 1'b0, 1'b0);
      read_chk(20'h000C0, 2'd2, 1, "R5");
      idle(5);
      read_chk(20'h000D0, 2'd2, 0, "R5");
      read_chk(20'h000C4, 2'd2, 0, "R5");

      @(negedge clk);
      rd_req = 1'b0;
      #1;
      // R2 no ready without a request
      check(rd_ready == 1'b0, "R2", "ready while idle", 32'(rd_ready), 32'd0);

      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule